// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is an on-chip scratchpad shared by a group of lanes that issue their accesses together. A single group request carries, for every lane, an enable, a word address, a write flag and write data. The storage is split into interleaved banks. The low address bits pick the bank and the remaining bits pick the row inside that bank, so lanes that walk through consecutive words land in different banks. Each bank has its own port and completes at most one word access per cycle.

Once a group is accepted, the block replays it over as few cycles as possible. In each cycle, every bank looks for the lowest-numbered lane that is still waiting on it and picks the word that lane wants. All waiting lanes that want that same word are then served together. A read of one word is broadcast to every lane that asked for it. Only different words in the same bank cost extra cycles.

While a group is being replayed, `busy` is high and new requests are ignored. When the last lane has been served, `done` pulses for one cycle. At that point the read data of all lanes is valid, and it stays valid until the next group is accepted.

Top module: `sp_scratchpad`

## Requirements
- R1: Bank mapping. The bank of a word address is its low log2(BANKS) bits, and its row is the remaining upper bits. A group whose enabled lanes all use distinct banks keeps `busy` high for exactly one cycle.
- R2: Acceptance. A group is accepted on a rising clock edge where `req_valid` is 1 and `busy` is 0, and `busy` is 1 after that edge. Lane inputs and `req_valid` seen while `busy` is 1 have no effect on the running group or on memory.
- R3: Replay length. After acceptance, `busy` stays high for N cycles and then falls. N is the largest number of distinct words that the enabled lanes request in any one bank, with a minimum of 1 (a group with no enabled lanes takes one cycle).
- R4: Broadcast. Any number of lanes that read the same word are served in the same cycle and all receive that word's value. Such a group adds no cycle beyond what R3 gives.
- R5: Read ordering. A read lane returns the value the word held before the group was accepted, even when another lane of the same group writes that word. Writes of a group are seen by every later group.
- R6: Write merge. When several enabled lanes of one group write the same word, the word ends up holding the data of the highest-numbered of those lanes.
- R7: Idle lanes. The read-data slot of a disabled lane or of a writing lane is zero. A disabled lane never writes memory.
- R8: Completion. `done` is 1 for exactly one cycle, the first cycle after `busy` falls. `rd_data` is valid in that cycle and holds its value until the next group is accepted.
- R9: Reset. While `rst_n` is low and after it is released, `busy` and `done` are 0 and `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A group request is present |
| lane_en | input | LANES | Per-lane enable |
| lane_we | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | LANES*ADDR_W | Per-lane word address; lane k occupies bits [k*ADDR_W +: ADDR_W] |
| lane_wdata | input | LANES*DATA_W | Per-lane write data; lane k occupies bits [k*DATA_W +: DATA_W] |
| busy | output | 1 | A group is being replayed |
| done | output | 1 | One-cycle pulse: the group has finished |
| rd_data | output | LANES*DATA_W | Per-lane read results; lane k occupies bits [k*DATA_W +: DATA_W] |

## Verification
The bench builds the block with 4 lanes, 4 banks, 16-bit words and 4-bit addresses, which gives 4 rows and 16 words in total. This size is small enough to sweep every one of the 256 ways of spreading four lanes over four banks. The sweep is run twice: once with distinct rows, to reach replay lengths from one to four cycles, and once with shared rows, to reach pure broadcast. After the sweeps, thousands of pseudo-random groups mix reads, writes, disabled lanes and colliding writers, and all checks compare against a 16-word reference array kept in the bench.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [0:0] {
      SP_IDLE   = 1'b0,
      SP_REPLAY = 1'b1
   } sp_phase_e;

   function automatic bit sp_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sp_bank_pick.sv
// Per-bank selector: picks the word of the lowest pending lane in this bank,
// marks every pending lane that wants that word, and merges writes so the
// highest-numbered writer wins.
module sp_bank_pick #(
   parameter int LANES   = 16,
   parameter int BANK_ID = 0,
   parameter int BANK_W  = 4,
   parameter int ROW_W   = 4,
   parameter int DATA_W  = 32
) (
   input  logic [LANES-1:0]        pend,
   input  logic [LANES*BANK_W-1:0] lane_bank,
   input  logic [LANES*ROW_W-1:0]  lane_row,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*DATA_W-1:0] lane_wdata,
   output logic [LANES-1:0]        served,
   output logic [ROW_W-1:0]        sel_row,
   output logic                    wr_en,
   output logic [DATA_W-1:0]       wr_data
);
   localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

   logic [LANES-1:0] in_bank;
   logic             found;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         in_bank[l] = pend[l] && (lane_bank[l*BANK_W +: BANK_W] == MY_BANK);
      end
   end

   always_comb begin
      found   = 1'b0;
      sel_row = '0;
      for (int l = 0; l < LANES; l++) begin
         if (!found && in_bank[l]) begin
            found   = 1'b1;
            sel_row = lane_row[l*ROW_W +: ROW_W];
         end
      end
   end

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         served[l] = in_bank[l] && (lane_row[l*ROW_W +: ROW_W] == sel_row);
      end
   end

   always_comb begin
      wr_en   = 1'b0;
      wr_data = '0;
      for (int l = 0; l < LANES; l++) begin
         if (served[l] && lane_we[l]) begin
            wr_en   = 1'b1;
            wr_data = lane_wdata[l*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/sp_bank_store.sv
// One bank: asynchronous read, synchronous write, one row per cycle.
module sp_bank_store #(
   parameter int ROW_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic [ROW_W-1:0]  row,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int ROWS = 1 << ROW_W;

   logic [DATA_W-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[row] <= wr_data;
      end
   end

   assign rd_data = mem[row];
endmodule

// File: rtl/sp_scratchpad.sv
module sp_scratchpad
   import sp_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int BANKS  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*ADDR_W-1:0] lane_addr,
   input  logic [LANES*DATA_W-1:0] lane_wdata,
   output logic                    busy,
   output logic                    done,
   output logic [LANES*DATA_W-1:0] rd_data
);
   localparam int BANK_W = $clog2(BANKS);
   localparam int ROW_W  = ADDR_W - BANK_W;

   // elaboration-time parameter checks
   if (!sp_is_pow2(BANKS) || BANKS < 2) begin : g_bad_banks
      $error("BANKS must be a power of two and at least 2");
   end
   if (ROW_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed log2(BANKS)");
   end
   if (LANES < 1 || DATA_W < 1) begin : g_bad_lanes
      $error("LANES and DATA_W must be positive");
   end

   sp_phase_e               phase;
   logic [LANES-1:0]        pending;
   logic [LANES-1:0]        lat_we;
   logic [LANES*ADDR_W-1:0] lat_addr;
   logic [LANES*DATA_W-1:0] lat_wdata;
   logic [LANES*DATA_W-1:0] result;
   logic                    done_q;

   logic [LANES*BANK_W-1:0] lane_bank;
   logic [LANES*ROW_W-1:0]  lane_row;
   logic [LANES-1:0]        served_bank [BANKS];
   logic [DATA_W-1:0]       bank_rd     [BANKS];
   logic [LANES-1:0]        served_all;
   logic [LANES-1:0]        remaining;
   logic [LANES*DATA_W-1:0] lane_rd;

   // address split: low bits select the bank, upper bits the row
   for (genvar l = 0; l < LANES; l++) begin : g_split
      assign lane_bank[l*BANK_W +: BANK_W] = lat_addr[l*ADDR_W +: BANK_W];
      assign lane_row[l*ROW_W +: ROW_W]    = lat_addr[l*ADDR_W + BANK_W +: ROW_W];
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [ROW_W-1:0]  row;
      logic              wen;
      logic [DATA_W-1:0] wdat;

      sp_bank_pick #(
         .LANES   (LANES),
         .BANK_ID (b),
         .BANK_W  (BANK_W),
         .ROW_W   (ROW_W),
         .DATA_W  (DATA_W)
      ) u_pick (
         .pend       (pending & {LANES{phase == SP_REPLAY}}),
         .lane_bank  (lane_bank),
         .lane_row   (lane_row),
         .lane_we    (lat_we),
         .lane_wdata (lat_wdata),
         .served     (served_bank[b]),
         .sel_row    (row),
         .wr_en      (wen),
         .wr_data    (wdat)
      );

      sp_bank_store #(
         .ROW_W  (ROW_W),
         .DATA_W (DATA_W)
      ) u_store (
         .clk     (clk),
         .row     (row),
         .wr_en   (wen),
         .wr_data (wdat),
         .rd_data (bank_rd[b])
      );
   end

   always_comb begin
      served_all = '0;
      for (int b = 0; b < BANKS; b++) begin
         served_all = served_all | served_bank[b];
      end
   end

   assign remaining = pending & ~served_all;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         lane_rd[l*DATA_W +: DATA_W] = bank_rd[lane_bank[l*BANK_W +: BANK_W]];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= SP_IDLE;
         pending   <= '0;
         lat_we    <= '0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         result    <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (phase == SP_IDLE) begin
            if (req_valid) begin
               lat_we    <= lane_we & lane_en;
               lat_addr  <= lane_addr;
               lat_wdata <= lane_wdata;
               pending   <= lane_en;
               result    <= '0;
               phase     <= SP_REPLAY;
            end
         end else begin
            pending <= remaining;
            for (int l = 0; l < LANES; l++) begin
               if (served_all[l] && !lat_we[l]) begin
                  result[l*DATA_W +: DATA_W] <= lane_rd[l*DATA_W +: DATA_W];
               end
            end
            if (remaining == '0) begin
               phase  <= SP_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy    = (phase == SP_REPLAY);
   assign done    = done_q;
   assign rd_data = result;

   // R2: the latched group does not move while a replay runs
   a_r2_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(lat_addr) && $stable(lat_wdata) && $stable(lat_we));

   // R3: every replay cycle serves a lane unless nothing is left
   a_r3_progress: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (served_all != '0) || (pending == '0));

   // R3: the set of waiting lanes only shrinks during a replay
   a_r3_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((pending & ~$past(pending)) == '0));

   // R8: completion is a single-cycle pulse right after the replay
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy) && !busy);
endmodule

// File: tb/sp_scratchpad_bench.sv
module sp_scratchpad_bench;
   localparam int L      = 4;
   localparam int B      = 4;
   localparam int D      = 16;
   localparam int A      = 4;
   localparam int WORDS  = 1 << A;
   localparam int ROWS   = WORDS / B;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [L-1:0]     lane_en = '0;
   logic [L-1:0]     lane_we = '0;
   logic [L*A-1:0]   lane_addr = '0;
   logic [L*D-1:0]   lane_wdata = '0;
   logic             busy;
   logic             done;
   logic [L*D-1:0]   rd_data;

   int n_tests = 0;
   int n_fail  = 0;

   logic [D-1:0] model [WORDS];
   logic [L-1:0] g_en, g_we;
   logic [A-1:0] g_addr  [L];
   logic [D-1:0] g_wdata [L];
   logic [31:0]  seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   sp_scratchpad #(.LANES(L), .BANKS(B), .DATA_W(D), .ADDR_W(A)) u_sp_scratchpad (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .lane_en(lane_en), .lane_we(lane_we), .lane_addr(lane_addr),
      .lane_wdata(lane_wdata), .busy(busy), .done(done), .rd_data(rd_data));

   function automatic logic [31:0] rnd(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one group, measure busy length, check results, update the model.
   task automatic run_group(input string tag);
      logic [D-1:0] exp_rd [L];
      int exp_n, cyc;
      for (int l = 0; l < L; l++)
         exp_rd[l] = (g_en[l] && !g_we[l]) ? model[g_addr[l]] : '0;
      exp_n = 1;
      for (int b = 0; b < B; b++) begin
         int cnt = 0;
         for (int r = 0; r < ROWS; r++) begin
            bit hit = 0;
            for (int l = 0; l < L; l++)
               if (g_en[l] && g_addr[l] == A'(r * B + b)) hit = 1;
            if (hit) cnt++;
         end
         if (cnt > exp_n) exp_n = cnt;
      end
      for (int l = 0; l < L; l++)
         if (g_en[l] && g_we[l]) model[g_addr[l]] = g_wdata[l];

      lane_en = g_en;
      lane_we = g_we;
      for (int l = 0; l < L; l++) begin
         lane_addr[l*A +: A]  = g_addr[l];
         lane_wdata[l*D +: D] = g_wdata[l];
      end
      req_valid = 1'b1;
      @(negedge clk);
      chk({tag, " R2 busy after accept"}, 64'(busy), 64'd1);
      cyc = 0;
      while (!done) begin
         if (busy) cyc++;
         // R2: junk offered during the replay must be ignored
         seed = rnd(seed);
         lane_en = '1;
         lane_we = '1;
         lane_addr = seed[L*A-1:0];
         lane_wdata = {L{seed[31:16]}};
         @(negedge clk);
      end
      req_valid = 1'b0;
      lane_en = '0;
      chk({tag, " R3 replay cycles"}, 64'(cyc), 64'(exp_n));
      chk({tag, " R8 busy low at done"}, 64'(busy), 64'd0);
      for (int l = 0; l < L; l++)
         chk({tag, " R5/R7 read data"}, 64'(rd_data[l*D +: D]), 64'(exp_rd[l]));
      @(negedge clk);
      chk({tag, " R8 done single pulse"}, 64'(done), 64'd0);
      for (int l = 0; l < L; l++)
         chk({tag, " R8 read data held"}, 64'(rd_data[l*D +: D]), 64'(exp_rd[l]));
   endtask

   task automatic clear_group();
      g_en = '0;
      g_we = '0;
      for (int l = 0; l < L; l++) begin
         g_addr[l]  = '0;
         g_wdata[l] = '0;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 busy in reset", 64'(busy), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 busy after reset", 64'(busy), 64'd0);
      chk("R9 done after reset", 64'(done), 64'd0);
      chk("R9 rd_data after reset", 64'(rd_data), 64'd0);

      // R1: fill memory with conflict-free groups of consecutive words
      for (int g = 0; g < WORDS / L; g++) begin
         clear_group();
         g_en = '1;
         g_we = '1;
         for (int l = 0; l < L; l++) begin
            g_addr[l]  = A'(g * L + l);
            g_wdata[l] = D'(16'hA000 + (g * L + l) * 16'h0111);
         end
         run_group("R1 fill");
      end
      // R1: read back consecutive words in one cycle
      for (int g = 0; g < WORDS / L; g++) begin
         clear_group();
         g_en = '1;
         for (int l = 0; l < L; l++) g_addr[l] = A'(g * L + l);
         run_group("R1 readback");
      end

      // R4: all lanes read one word
      clear_group();
      g_en = '1;
      for (int l = 0; l < L; l++) g_addr[l] = 4'd6;
      run_group("R4 broadcast");

      // R3: every lane a different row of bank 1
      clear_group();
      g_en = '1;
      for (int l = 0; l < L; l++) g_addr[l] = A'(l * B + 1);
      run_group("R3 full conflict");

      // R6: three writers on one word, then read it
      clear_group();
      g_en = 4'b1110;
      g_we = 4'b1110;
      for (int l = 0; l < L; l++) begin
         g_addr[l]  = 4'd9;
         g_wdata[l] = D'(16'h5A00 + l);
      end
      run_group("R6 write merge");
      clear_group();
      g_en = 4'b0001;
      g_addr[0] = 4'd9;
      run_group("R6 readback");
      chk("R6 winner is lane 3", 64'(rd_data[D-1:0]), 64'h5A03);

      // R5: read and write of one word in the same group
      clear_group();
      g_en = 4'b0011;
      g_we = 4'b0010;
      g_addr[0] = 4'd3;  g_addr[1] = 4'd3;
      g_wdata[1] = 16'hBEEF;
      run_group("R5 same group rw");
      clear_group();
      g_en = 4'b0001;
      g_addr[0] = 4'd3;
      run_group("R5 later group");
      chk("R5 write visible later", 64'(rd_data[D-1:0]), 64'hBEEF);

      // R7: disabled lanes neither write nor return data; empty group
      clear_group();
      g_en = 4'b0000;
      g_we = 4'b1111;
      for (int l = 0; l < L; l++) begin
         g_addr[l] = A'(l);
         g_wdata[l] = 16'hDEAD;
      end
      run_group("R7 empty group");
      clear_group();
      g_en = '1;
      for (int l = 0; l < L; l++) g_addr[l] = A'(l);
      run_group("R7 no stray write");

      // R3: exhaustive bank spreads with distinct rows, then shared rows (R4)
      for (int p = 0; p < 256; p++) begin
         clear_group();
         g_en = '1;
         for (int l = 0; l < L; l++) g_addr[l] = A'(l * B + ((p >> (2 * l)) & 3));
         run_group("R3 sweep rows");
      end
      for (int p = 0; p < 256; p++) begin
         clear_group();
         g_en = '1;
         for (int l = 0; l < L; l++) g_addr[l] = A'(B + ((p >> (2 * l)) & 3));
         run_group("R4 sweep shared");
      end

      // mixed pseudo-random groups
      for (int i = 0; i < 3000; i++) begin
         clear_group();
         seed = rnd(seed);
         g_en = seed[3:0];
         g_we = seed[7:4];
         for (int l = 0; l < L; l++) begin
            seed = rnd(seed);
            g_addr[l]  = seed[19:16] & (seed[31] ? 4'hF : 4'h5);
            g_wdata[l] = seed[15:0];
         end
         run_group("R5 R6 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule